// File: doc/BRIEF.md
# Two-Master Chained Interrupt Aggregator

This block collects 112 interrupt inputs and folds them into one summary interrupt line. The inputs are arranged as two masters, each with seven blocks of eight inputs. A rising edge on an unmasked input sets a sticky pending bit. Software clears that bit by writing ones to it. Each block has four views, and every view is addressed directly with no select register in between: pending bits, a clear port on the same address, a mask byte, and the raw input levels. Each master also has a summary byte in which bits 7:1 show which of its blocks hold unmasked pending bits. Bit 0 of the master 0 summary is a cascade bit: it is set when any block of master 1 is pending. A handler can therefore read master 0 first and visit master 1 only when bit 0 asks it to.

Software reaches the registers through a byte-wide request port. An access control state machine serves this port. It has three named states. ST_IDLE accepts a request and captures the address, the direction and the data. ST_DECODE registers the decoded target: which view, which master and which block. ST_EXEC applies the write or samples the read data, raises a one-cycle acknowledge, and returns to ST_IDLE. The transitions run ST_IDLE to ST_DECODE on req, ST_DECODE to ST_EXEC always, and ST_EXEC to ST_IDLE always. Without req the machine stays in ST_IDLE.

Top module: `chain_irq_aggregator`

## Requirements
- R1: After reset every input is masked, every mask byte reads 0xFF, every pending bit is cleared, and irq_out and ack are 0.
- R2: A request sampled in ST_IDLE is served with ack high for exactly one cycle, on the third clock edge counted from the edge that accepted it. Requests that arrive while an access is in progress are ignored.
- R3: A pending bit is set only by a 0-to-1 change of an unmasked input. An input that is masked at the time of its edge, or that stays high without a new edge, sets nothing.
- R4: With master base B (0x130 for master 0, 0x1B0 for master 1), a read of B+k for block k (1..7) returns the unmasked pending byte of that block. Bit i of that byte belongs to interrupt number (m*7+k-1)*8+i.
- R5: A write to B+k clears the pending bits at the positions written as 1 and leaves the others alone. If a rising edge arrives on the same clock edge as the clear, the edge wins.
- R6: The mask byte of block k sits at B+7+k, reads back what was written, and a 1 masks that input. A pending bit that is masked is hidden from reads and summaries and shows again when the input is unmasked.
- R7: A read of B+14+k returns the present raw levels of the block's eight inputs, whatever the mask.
- R8: A read of B+0 returns the master summary. Bit k (1..7) is set when block k of that master has an unmasked pending bit. Bit 0 of master 0 is the OR of the master 1 summary, and bit 0 of master 1 reads 0.
- R9: irq_out is the OR of all bits of the master 0 summary.
- R10: Addresses outside the two decoded windows read 0. Writes to them, to a summary address or to a raw-level address change nothing.
- R11: irq_out falls only on the edge at which a register write is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_in | input | 112 | Interrupt inputs; bit n is interrupt number n |
| req | input | 1 | Access request, sampled in ST_IDLE |
| wr_en | input | 1 | 1 for write, 0 for read |
| addr | input | 10 | Register address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle pulse when the access completes |
| rdata | output | 8 | Read data, valid while ack is high |
| irq_out | output | 1 | Summary interrupt |

## Verification
The hardest case to reach is a rising edge on an input that lands on the same clock edge as a clear of that bit. Reaching it means counting the access pipeline exactly. The bench latches a bit, issues the clear, and raises the input at the falling edge just before the ST_EXEC edge; it then reads back to confirm the bit survived. A second hard case is a request held high across a busy access. The bench shows that it is ignored by reading back the mask byte that the dropped request would have changed. Random input patterns, mask writes and clears then run against a bench model of the pending and mask state.

// File: rtl/chain_irq_pkg.sv
package chain_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2
    } acc_state_t;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_SUMMARY = 3'd1,
        KIND_STATUS  = 3'd2,
        KIND_MASK    = 3'd3,
        KIND_LIVE    = 3'd4
    } reg_kind_t;

    localparam int LANE_W = 8;
    localparam int BLK_W  = 3;

    typedef struct packed {
        reg_kind_t        kind;
        logic             mst;
        logic [BLK_W-1:0] blk;
    } reg_sel_t;

endpackage

// File: rtl/chain_addr_decode.sv
module chain_addr_decode
    import chain_irq_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int M0_BASE = 'h130,
    parameter int M1_BASE = 'h1B0,
    parameter int BPM     = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int MASK_OFF = BPM;
    localparam int LIVE_OFF = 2 * BPM;
    localparam int LAST_OFF = 3 * BPM;

    always_comb begin
        int off;
        sel = '{kind: KIND_NONE, mst: 1'b0, blk: '0};
        off = 0;
        for (int m = 0; m < 2; m++) begin
            off = int'(addr) - ((m == 0) ? M0_BASE : M1_BASE);
            if (off == 0) begin
                sel.kind = KIND_SUMMARY;
                sel.mst  = (m != 0);
            end else if (off >= 1 && off <= MASK_OFF) begin
                sel.kind = KIND_STATUS;
                sel.mst  = (m != 0);
                sel.blk  = BLK_W'(off - 1);
            end else if (off > MASK_OFF && off <= LIVE_OFF) begin
                sel.kind = KIND_MASK;
                sel.mst  = (m != 0);
                sel.blk  = BLK_W'(off - MASK_OFF - 1);
            end else if (off > LIVE_OFF && off <= LAST_OFF) begin
                sel.kind = KIND_LIVE;
                sel.mst  = (m != 0);
                sel.blk  = BLK_W'(off - LIVE_OFF - 1);
            end
        end
    end

endmodule

// File: rtl/chain_irq_bank.sv
module chain_irq_bank
    import chain_irq_pkg::*;
#(
    parameter int NBLK  = 14,
    parameter int IDX_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBLK*LANE_W-1:0]   irq_in,
    input  logic                     clr_en,
    input  logic                     mask_en,
    input  logic [IDX_W-1:0]         wr_blk,
    input  logic [LANE_W-1:0]        wdata,
    output logic [NBLK*LANE_W-1:0]   pend,
    output logic [NBLK*LANE_W-1:0]   mask_q
);

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [LANE_W-1:0] lat_q;
        logic [LANE_W-1:0] msk_q;
        logic [LANE_W-1:0] prev_q;
        logic [LANE_W-1:0] cur;
        logic [LANE_W-1:0] rise;
        logic [LANE_W-1:0] kill;
        logic              hit;

        assign cur  = irq_in[g*LANE_W +: LANE_W];
        assign hit  = (wr_blk == IDX_W'(g));
        assign rise = cur & ~prev_q & ~msk_q;
        assign kill = (clr_en && hit) ? wdata : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q  <= '0;
                msk_q  <= '1;
                prev_q <= '0;
            end else begin
                prev_q <= cur;
                lat_q  <= (lat_q & ~kill) | rise;
                if (mask_en && hit) begin
                    msk_q <= wdata;
                end
            end
        end

        assign pend[g*LANE_W +: LANE_W]   = lat_q & ~msk_q;
        assign mask_q[g*LANE_W +: LANE_W] = msk_q;
    end

endmodule

// File: rtl/chain_summary.sv
module chain_summary
    import chain_irq_pkg::*;
#(
    parameter int BPM = 7
) (
    input  logic [2*BPM*LANE_W-1:0] pend,
    output logic [LANE_W-1:0]       sum0,
    output logic [LANE_W-1:0]       sum1,
    output logic                    irq_out
);

    localparam int NBLK = 2 * BPM;

    logic [NBLK-1:0] blk_any;

    for (genvar g = 0; g < NBLK; g++) begin : g_any
        assign blk_any[g] = |pend[g*LANE_W +: LANE_W];
    end

    always_comb begin
        sum1          = '0;
        sum1[BPM:1]   = blk_any[NBLK-1:BPM];
        sum0          = '0;
        sum0[BPM:1]   = blk_any[BPM-1:0];
        sum0[0]       = |sum1;
    end

    assign irq_out = |sum0;

endmodule

// File: rtl/chain_irq_aggregator.sv
module chain_irq_aggregator
    import chain_irq_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int M0_BASE = 'h130,
    parameter int M1_BASE = 'h1B0,
    parameter int BPM     = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*BPM*8-1:0]       irq_in,
    input  logic                     req,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic                     ack,
    output logic [7:0]               rdata,
    output logic                     irq_out
);

    localparam int NBLK  = 2 * BPM;
    localparam int NIRQ  = NBLK * LANE_W;
    localparam int IDX_W = $clog2(NBLK);

    acc_state_t          state_q;
    acc_state_t          state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic                we_q;
    logic [LANE_W-1:0]   wdata_q;
    reg_sel_t            sel_comb;
    reg_sel_t            sel_q;
    logic [IDX_W-1:0]    gblk;
    logic                clr_en;
    logic                mask_en;
    logic [NIRQ-1:0]     pend;
    logic [NIRQ-1:0]     mask_all;
    logic [LANE_W-1:0]   sum0;
    logic [LANE_W-1:0]   sum1;
    logic [LANE_W-1:0]   rd_val;
    logic                in_exec;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture and decode pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            sel_q   <= '{kind: KIND_NONE, mst: 1'b0, blk: '0};
        end else begin
            if (state_q == ST_IDLE && req) begin
                addr_q  <= addr;
                we_q    <= wr_en;
                wdata_q <= wdata;
            end
            if (state_q == ST_DECODE) begin
                sel_q <= sel_comb;
            end
        end
    end

    chain_addr_decode #(
        .ADDR_W  (ADDR_W),
        .M0_BASE (M0_BASE),
        .M1_BASE (M1_BASE),
        .BPM     (BPM)
    ) u_decode (
        .addr (addr_q),
        .sel  (sel_comb)
    );

    assign in_exec = (state_q == ST_EXEC);
    assign gblk    = (sel_q.mst ? IDX_W'(BPM) : IDX_W'(0)) + IDX_W'(sel_q.blk);
    assign clr_en  = in_exec && we_q && (sel_q.kind == KIND_STATUS);
    assign mask_en = in_exec && we_q && (sel_q.kind == KIND_MASK);

    chain_irq_bank #(
        .NBLK  (NBLK),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .clr_en  (clr_en),
        .mask_en (mask_en),
        .wr_blk  (gblk),
        .wdata   (wdata_q),
        .pend    (pend),
        .mask_q  (mask_all)
    );

    chain_summary #(
        .BPM (BPM)
    ) u_summary (
        .pend    (pend),
        .sum0    (sum0),
        .sum1    (sum1),
        .irq_out (irq_out)
    );

    // read data select
    always_comb begin
        rd_val = '0;
        unique case (sel_q.kind)
            KIND_SUMMARY: rd_val = sel_q.mst ? sum1 : sum0;
            KIND_STATUS:  rd_val = pend[int'(gblk)*LANE_W +: LANE_W];
            KIND_MASK:    rd_val = mask_all[int'(gblk)*LANE_W +: LANE_W];
            KIND_LIVE:    rd_val = irq_in[int'(gblk)*LANE_W +: LANE_W];
            default:      rd_val = '0;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= in_exec;
            if (in_exec) begin
                rdata <= we_q ? '0 : rd_val;
            end
        end
    end

endmodule

// File: rtl/chain_irq_aggregator_chk.sv
module chain_irq_aggregator_chk
    import chain_irq_pkg::*;
#(
    parameter int NIRQ = 112
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NIRQ-1:0]  irq_in,
    input logic [NIRQ-1:0]  mask_all,
    input acc_state_t       state_q,
    input logic             ack,
    input logic             irq_out
);

    logic [NIRQ-1:0] irq_d;
    logic            exec_now;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_d <= '0;
        else        irq_d <= irq_in;
    end

    assign exec_now = (state_q == ST_EXEC);

    // R3: an unmasked rising edge outside a write edge raises irq_out
    a_r3_rise_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(irq_in & ~irq_d & ~mask_all)) && !exec_now) |=> irq_out);

    // R2: ack follows the execute state
    a_r2_ack_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec_now |=> ack);

    // R2: ack never appears without a preceding execute state
    a_r2_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(exec_now));

    // R2: ack lasts one cycle
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R11: summary output drops only when a write is applied
    a_r11_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(exec_now));

endmodule

bind chain_irq_aggregator chain_irq_aggregator_chk #(.NIRQ(NIRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .mask_all (mask_all),
    .state_q  (state_q),
    .ack      (ack),
    .irq_out  (irq_out)
);

// File: tb/chain_irq_aggregator_tb.sv
module chain_irq_aggregator_tb;

    localparam int NIRQ = 112;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq_in = '0;
    logic            req = 1'b0;
    logic            wr_en = 1'b0;
    logic [9:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic            ack;
    logic [7:0]      rdata;
    logic            irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NIRQ-1:0] m_lat  = '0;
    logic [NIRQ-1:0] m_mask = '1;
    logic [NIRQ-1:0] m_in   = '0;

    always #2 clk = ~clk;

    chain_irq_aggregator u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .req     (req),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ack     (ack),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // kind: 0 summary, 1 status/clear, 2 mask, 3 raw levels
    function automatic logic [9:0] ra(input int m, input int kind, input int k);
        int base;
        int off;
        base = (m == 0) ? 'h130 : 'h1B0;
        off  = (kind == 0) ? 0 : (kind == 1) ? k : (kind == 2) ? 7 + k : 14 + k;
        return 10'(base + off);
    endfunction

    function automatic logic [7:0] exp_sum(input int m);
        logic [7:0]      s;
        logic [NIRQ-1:0] p;
        p = m_lat & ~m_mask;
        s = '0;
        for (int k = 1; k <= 7; k++) s[k] = |p[(m*7+k-1)*8 +: 8];
        if (m == 0) begin
            for (int k = 1; k <= 7; k++) s[0] = s[0] | (|p[(7+k-1)*8 +: 8]);
        end
        return s;
    endfunction

    function automatic logic [7:0] exp_read(input int m, input int kind, input int k);
        int g;
        g = m*7 + k - 1;
        case (kind)
            0: return exp_sum(m);
            1: return m_lat[g*8 +: 8] & ~m_mask[g*8 +: 8];
            2: return m_mask[g*8 +: 8];
            default: return m_in[g*8 +: 8];
        endcase
    endfunction

    task automatic access(input bit w, input logic [9:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        req = 1'b1; wr_en = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk("R2 no early ack", 32'(ack), 32'd0);
        @(negedge clk);
        chk("R2 ack on third edge", 32'(ack), 32'd1);
        rd = rdata;
        @(negedge clk);
        chk("R2 ack one cycle", 32'(ack), 32'd0);
    endtask

    task automatic wr_reg(input int m, input int kind, input int k, input logic [7:0] d);
        logic [7:0] unused_rd;
        int g;
        g = m*7 + k - 1;
        access(1'b1, ra(m, kind, k), d, unused_rd);
        if (kind == 1) m_lat[g*8 +: 8]  = m_lat[g*8 +: 8] & ~d;
        if (kind == 2) m_mask[g*8 +: 8] = d;
    endtask

    task automatic rd_chk(input string rq, input int m, input int kind, input int k);
        logic [7:0] rd;
        access(1'b0, ra(m, kind, k), 8'h00, rd);
        chk(rq, 32'(rd), 32'(exp_read(m, kind, k)));
    endtask

    task automatic set_inputs(input logic [NIRQ-1:0] v);
        @(negedge clk);
        m_lat  = m_lat | (v & ~m_in & ~m_mask);
        m_in   = v;
        irq_in = v;
        @(negedge clk);
        chk("R9 irq_out after input change", 32'(irq_out), 32'(|exp_sum(0)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_out after reset", 32'(irq_out), 32'd0);
        chk("R1 ack after reset", 32'(ack), 32'd0);
        rd_chk("R1 mask m0 k1 all set", 0, 2, 1);
        rd_chk("R1 mask m1 k7 all set", 1, 2, 7);
        rd_chk("R1 status m0 k3 clear", 0, 1, 3);
        rd_chk("R1 summary m0 clear", 0, 0, 0);

        // R3 masked edges are not recorded; R7 raw levels ignore mask
        set_inputs('1);
        chk("R3 masked edges give no irq", 32'(irq_out), 32'd0);
        rd_chk("R7 raw levels of m1 k5", 1, 3, 5);
        rd_chk("R3 status stays clear", 1, 1, 5);
        set_inputs('0);

        // R4, R8, R9 chain through master 1 block 7 (interrupt 109)
        wr_reg(1, 2, 7, 8'h00);
        rd_chk("R6 mask read back", 1, 2, 7);
        set_inputs(NIRQ'(1) << 109);
        chk("R9 irq_out from master 1", 32'(irq_out), 32'd1);
        rd_chk("R4 status m1 k7 bit 5", 1, 1, 7);
        rd_chk("R8 summary m1 bit 7", 1, 0, 0);
        rd_chk("R8 summary m0 cascade bit 0", 0, 0, 0);

        // R5 clear; R3 steady high level does not relatch
        wr_reg(1, 1, 7, 8'h20);
        chk("R5 clear drops irq_out", 32'(irq_out), 32'd0);
        repeat (5) @(negedge clk);
        chk("R3 level without edge", 32'(irq_out), 32'd0);
        rd_chk("R5 status after clear", 1, 1, 7);
        set_inputs('0);

        // R6 masking hides a pending bit and unmasking shows it again
        wr_reg(0, 2, 1, 8'hFB);
        set_inputs(NIRQ'(1) << 2);
        rd_chk("R4 status m0 k1 bit 2", 0, 1, 1);
        wr_reg(0, 2, 1, 8'hFF);
        chk("R6 masked bit hides irq_out", 32'(irq_out), 32'd0);
        rd_chk("R6 masked bit hidden in status", 0, 1, 1);
        wr_reg(0, 2, 1, 8'hFB);
        chk("R6 unmask restores irq_out", 32'(irq_out), 32'd1);
        rd_chk("R6 unmasked bit shows", 0, 1, 1);
        set_inputs('0);

        // R5 edge on the clear edge survives
        @(negedge clk);
        req = 1'b1; wr_en = 1'b1; addr = ra(0, 1, 1); wdata = 8'h04;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        irq_in = NIRQ'(1) << 2;
        m_in   = irq_in;
        @(negedge clk);
        chk("R2 ack with same-edge clear", 32'(ack), 32'd1);
        @(negedge clk);
        rd_chk("R5 edge wins over clear", 0, 1, 1);
        chk("R5 irq_out kept by edge", 32'(irq_out), 32'd1);
        wr_reg(0, 1, 1, 8'h04);
        rd_chk("R5 later clear works", 0, 1, 1);
        set_inputs('0);

        // R2 request held during a busy access is ignored
        @(negedge clk);
        req = 1'b1; wr_en = 1'b1; addr = ra(0, 2, 3); wdata = 8'h00;
        @(negedge clk);
        addr = ra(0, 2, 4);
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        m_mask[2*8 +: 8] = 8'h00;
        rd_chk("R2 busy request ignored, m0 k4 mask", 0, 2, 4);
        rd_chk("R2 accepted write landed, m0 k3 mask", 0, 2, 3);

        // R10 unmapped and read-only addresses
        access(1'b0, 10'h100, 8'h00, rd);
        chk("R10 unmapped read 0x100", 32'(rd), 32'd0);
        access(1'b0, 10'h146, 8'h00, rd);
        chk("R10 unmapped read after window", 32'(rd), 32'd0);
        access(1'b1, 10'h150, 8'h00, rd);
        access(1'b1, ra(0, 3, 1), 8'h00, rd);
        access(1'b1, ra(0, 0, 0), 8'h00, rd);
        access(1'b1, 10'h1C6, 8'h00, rd);
        rd_chk("R10 mask m0 k1 untouched", 0, 2, 1);
        rd_chk("R10 mask m1 k1 untouched", 1, 2, 1);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            int m;
            int k;
            op = int'($urandom % 4);
            m  = int'($urandom % 2);
            k  = 1 + int'($urandom % 7);
            case (op)
                0: set_inputs({$urandom, $urandom, $urandom, $urandom} & {NIRQ{1'b1}});
                1: wr_reg(m, 2, k, 8'($urandom) & 8'($urandom));
                2: wr_reg(m, 1, k, 8'($urandom));
                default: rd_chk("R4 R6 R7 R8 random read", m, int'($urandom % 4), k);
            endcase
            chk("R9 irq_out random", 32'(irq_out), 32'(|exp_sum(0)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule